// File: doc/BRIEF.md
# Pointer-Indexed Configuration Register Bank

This block is the software-visible configuration port set of a two-channel disk interface controller. A small register bus with a two-bit address reaches four ports. The data port (address 0) gives access to one of fourteen configuration registers, seven for each channel. Which register it reaches is chosen by the pointer port (address 1): bits 2..0 pick the register index and bit 3 picks the channel bank. Address 2 is a test/mode register when written and a channel 0 interrupt status register when read. Address 3 holds the per-channel interrupt masks and reports the channel 1 interrupt status and the legacy-header strap.

When bit 7 of the pointer is set, the index advances by one after every read or write of the data port. Software can therefore stream a whole bank through the data port without rewriting the pointer. The stored fields of both banks drive the controller through dedicated outputs. These fields are the command-block and control-block base addresses, the general configuration byte, the read-ahead count and flags, and the two timing bytes. A write with the clear-FIFO bit set produces a single-cycle pulse for the addressed channel. Each channel's interrupt output is its drive and bus-master interrupt inputs ORed together and gated by the channel's mask bit.

Top module: `cfg_ptr_bank`

## Requirements
- R1: After reset the pointer reads 0x50. Primary bank values are index 0 = 0x1F0, index 1 = 0x01, index 4 = 0x3F6, index 5 = 0xF5 and index 6 = 0xDE. The secondary bank matches it except index 0 = 0x170 and index 4 = 0x376. The masks and the test/mode bits reset to 0.
- R2: A write to address 1 stores bits 7..0 of the write data as the pointer: bits 2..0 are the index and bit 3 is the channel (0 primary, 1 secondary). A read of address 1 returns the pointer with bit 5 forced to 0.
- R3: While pointer bit 7 is 1, each data port access (read or write) advances the index by one, and index 6 or 7 steps to 0. While bit 7 is 0, data port accesses leave the index unchanged.
- R4: Indexes 0 and 4 are 16-bit read/write base registers that drive cmd_base_o and ctl_base_o.
- R5: Index 1 is an 8-bit general configuration byte driving gen_cfg_o, and reading it returns bit 2 as 0. Indexes 5 and 6 are 8-bit timing bytes driving dtime_o and ctime_o. Bits 15..8 read as 0 for all three.
- R6: Indexes 2 and 3 read as 0. The read-ahead count on ra_count_o is bits 1..0 of the last index 3 write above the 8 bits of the last index 2 write. Index 3 bit 7 is stored as ra_en_o and bit 4 as mode4_o.
- R7: A write to index 3 with bit 6 set pulses that channel's fifo_clr_o bit high for exactly the one cycle after the write edge, and the bit is not stored.
- R8: Index 7 reads as 0, and writes to it change no output.
- R9: A write to address 2 sets test_mode_o from bit 0 and legacy_mode_o from bit 1. A read of address 2 returns bm_irq[0] in bit 1 and drv_irq[0] in bit 0, with all other bits 0.
- R10: Address 3 stores write bits 1..0 as the mask bits, with bit c masking channel c. A read of address 3 returns legacy_hdr in bit 4, bm_irq[1] in bit 3, drv_irq[1] in bit 2 and the mask in bits 1..0.
- R11: irq_out[c] equals (drv_irq[c] OR bm_irq[c]) AND NOT mask[c], combinationally.
- R12: bus_rdata takes the addressed value on the clock edge where bus_re is sampled high, using the pointer as it was before any advance. After an edge with bus_re low it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port select: 0 data, 1 pointer, 2 test/status, 3 mask/status |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| drv_irq | input | 2 | Drive interrupt per channel |
| bm_irq | input | 2 | Bus-master interrupt per channel |
| legacy_hdr | input | 1 | Legacy header present strap |
| irq_out | output | 2 | Masked interrupt per channel |
| cmd_base_o | output | 32 | Command-block base, channel 0 in bits 15..0 |
| ctl_base_o | output | 32 | Control-block base, channel 0 in bits 15..0 |
| gen_cfg_o | output | 16 | General configuration byte per channel |
| ra_count_o | output | 20 | 10-bit read-ahead count per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| mode4_o | output | 2 | Fast timing control per channel |
| dtime_o | output | 16 | Data port timing byte per channel |
| ctime_o | output | 16 | Command port timing byte per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per channel |
| test_mode_o | output | 1 | Test mode bit |
| legacy_mode_o | output | 1 | Legacy compatible mode bit |

## Verification
Two pairs of functions can meet in one cycle. The first is a mask write at address 3 on the same edge where an interrupt input changes. The second is a data port read on the same edge where the pointer auto-advances. The bench provokes the first by driving drv_irq and the mask write together, then comparing irq_out each cycle against a model that applies the old mask until the edge and the new one after it. It provokes the second by streaming reads with bit 7 of the pointer set across the 6-to-0 wrap, where each returned value must belong to the index held before the advance.

// File: rtl/cfg_ptr_pkg.sv
package cfg_ptr_pkg;

  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_PTR  = 2'd1,
    PORT_TEST = 2'd2,
    PORT_IRQ  = 2'd3
  } port_e;

  localparam int IDX_W    = 3;
  localparam int LAST_IDX = 6;

  function automatic logic [15:0] cmd_base_rst(input int ch);
    return (ch != 0) ? 16'h0170 : 16'h01F0;
  endfunction

  function automatic logic [15:0] ctl_base_rst(input int ch);
    return (ch != 0) ? 16'h0376 : 16'h03F6;
  endfunction

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] idx);
    return (int'(idx) >= LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  function automatic logic [7:0] ptr_readback(input logic [7:0] p);
    return p & 8'hDF;
  endfunction

endpackage

// File: rtl/cfg_ptr_ptr.sv
module cfg_ptr_ptr
  import cfg_ptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic             data_acc,
  input  logic [7:0]       wbyte,
  output logic [7:0]       ptr_q,
  output logic [IDX_W-1:0] idx,
  output logic             chan,
  output logic             step
);

  localparam logic [7:0] PTR_RST = 8'h50;

  assign step = data_acc & ptr_q[7];
  assign idx  = ptr_q[IDX_W-1:0];
  assign chan = ptr_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_RST;
    end else if (ptr_wr) begin
      ptr_q <= wbyte;
    end else if (step) begin
      ptr_q[IDX_W-1:0] <= next_index(ptr_q[IDX_W-1:0]);
    end
  end

endmodule

// File: rtl/cfg_ptr_chan.sv
module cfg_ptr_chan
  import cfg_ptr_pkg::*;
#(
  parameter int CH   = 0,
  parameter int DW   = 16,
  parameter int RA_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    cmd_base,
  output logic [DW-1:0]    ctl_base,
  output logic [7:0]       gen_cfg,
  output logic [RA_W-1:0]  ra_count,
  output logic             ra_en,
  output logic             mode4,
  output logic [7:0]       dtime,
  output logic [7:0]       ctime,
  output logic             fifo_clr
);

  localparam int RA_HI_W = RA_W - 8;
  localparam logic [7:0] GEN_RST  = 8'h01;
  localparam logic [7:0] GEN_RDM  = 8'hFB;
  localparam logic [7:0] DT_RST   = 8'hF5;
  localparam logic [7:0] CT_RST   = 8'hDE;

  logic [DW-1:0]      cmd_q, ctl_q;
  logic [7:0]         gen_q, dt_q, ct_q, ra_lo_q;
  logic [RA_HI_W-1:0] ra_hi_q;
  logic               ra_en_q, m4_q, clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= cmd_base_rst(CH);
      ctl_q   <= ctl_base_rst(CH);
      gen_q   <= GEN_RST;
      dt_q    <= DT_RST;
      ct_q    <= CT_RST;
      ra_lo_q <= '0;
      ra_hi_q <= '0;
      ra_en_q <= 1'b0;
      m4_q    <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (wr) begin
        case (idx)
          3'd0: cmd_q <= wdata;
          3'd1: gen_q <= wdata[7:0];
          3'd2: ra_lo_q <= wdata[7:0];
          3'd3: begin
            ra_hi_q <= wdata[RA_HI_W-1:0];
            ra_en_q <= wdata[7];
            m4_q    <= wdata[4];
            clr_q   <= wdata[6];
          end
          3'd4: ctl_q <= wdata;
          3'd5: dt_q  <= wdata[7:0];
          3'd6: ct_q  <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0:    rdata = cmd_q;
      3'd1:    rdata = {{(DW-8){1'b0}}, gen_q & GEN_RDM};
      3'd4:    rdata = ctl_q;
      3'd5:    rdata = {{(DW-8){1'b0}}, dt_q};
      3'd6:    rdata = {{(DW-8){1'b0}}, ct_q};
      default: rdata = '0;
    endcase
  end

  assign cmd_base = cmd_q;
  assign ctl_base = ctl_q;
  assign gen_cfg  = gen_q;
  assign ra_count = {ra_hi_q, ra_lo_q};
  assign ra_en    = ra_en_q;
  assign mode4    = m4_q;
  assign dtime    = dt_q;
  assign ctime    = ct_q;
  assign fifo_clr = clr_q;

endmodule

// File: rtl/cfg_ptr_irq.sv
module cfg_ptr_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           test_wr,
  input  logic           mask_wr,
  input  logic [7:0]     wbyte,
  input  logic [NCH-1:0] drv_irq,
  input  logic [NCH-1:0] bm_irq,
  input  logic           legacy_hdr,
  output logic [NCH-1:0] mask_q,
  output logic           test_mode,
  output logic           legacy_mode,
  output logic [7:0]     status_byte,
  output logic [7:0]     irqreg_byte,
  output logic [NCH-1:0] irq_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      test_mode   <= 1'b0;
      legacy_mode <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wbyte[NCH-1:0];
      if (test_wr) begin
        test_mode   <= wbyte[0];
        legacy_mode <= wbyte[1];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_gate
    assign irq_out[c] = (drv_irq[c] | bm_irq[c]) & ~mask_q[c];
  end

  assign status_byte = {6'b0, bm_irq[0], drv_irq[0]};
  assign irqreg_byte = {3'b0, legacy_hdr, bm_irq[1], drv_irq[1], mask_q[1:0]};

endmodule

// File: rtl/cfg_ptr_bank.sv
module cfg_ptr_bank
  import cfg_ptr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [1:0]        drv_irq,
  input  logic [1:0]        bm_irq,
  input  logic              legacy_hdr,
  output logic [1:0]        irq_out,
  output logic [2*DW-1:0]   cmd_base_o,
  output logic [2*DW-1:0]   ctl_base_o,
  output logic [15:0]       gen_cfg_o,
  output logic [2*RA_W-1:0] ra_count_o,
  output logic [1:0]        ra_en_o,
  output logic [1:0]        mode4_o,
  output logic [15:0]       dtime_o,
  output logic [15:0]       ctime_o,
  output logic [1:0]        fifo_clr_o,
  output logic              test_mode_o,
  output logic              legacy_mode_o
);

  localparam int NCH = 2;

  logic             sel_data, sel_ptr, sel_test, sel_irq;
  logic             data_acc, ptr_wr;
  logic [7:0]       ptr_q;
  logic [IDX_W-1:0] ptr_idx;
  logic             ptr_chan, ptr_step;
  logic [NCH-1:0]   mask_q;
  logic [7:0]       status_byte, irqreg_byte;
  logic [DW-1:0]    bank_rd [NCH];
  logic [DW-1:0]    rd_mux, rdata_q;

  assign sel_data = (bus_addr == PORT_DATA);
  assign sel_ptr  = (bus_addr == PORT_PTR);
  assign sel_test = (bus_addr == PORT_TEST);
  assign sel_irq  = (bus_addr == PORT_IRQ);
  assign data_acc = sel_data & (bus_we | bus_re);
  assign ptr_wr   = sel_ptr & bus_we;

  cfg_ptr_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_wr   (ptr_wr),
    .data_acc (data_acc),
    .wbyte    (bus_wdata[7:0]),
    .ptr_q    (ptr_q),
    .idx      (ptr_idx),
    .chan     (ptr_chan),
    .step     (ptr_step)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic bank_wr;
    assign bank_wr = sel_data & bus_we & (ptr_chan == c[0]);
    cfg_ptr_chan #(.CH(c), .DW(DW), .RA_W(RA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bank_wr),
      .idx      (ptr_idx),
      .wdata    (bus_wdata),
      .rdata    (bank_rd[c]),
      .cmd_base (cmd_base_o[c*DW +: DW]),
      .ctl_base (ctl_base_o[c*DW +: DW]),
      .gen_cfg  (gen_cfg_o[c*8 +: 8]),
      .ra_count (ra_count_o[c*RA_W +: RA_W]),
      .ra_en    (ra_en_o[c]),
      .mode4    (mode4_o[c]),
      .dtime    (dtime_o[c*8 +: 8]),
      .ctime    (ctime_o[c*8 +: 8]),
      .fifo_clr (fifo_clr_o[c])
    );
  end

  cfg_ptr_irq #(.NCH(NCH)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_wr     (sel_test & bus_we),
    .mask_wr     (sel_irq & bus_we),
    .wbyte       (bus_wdata[7:0]),
    .drv_irq     (drv_irq),
    .bm_irq      (bm_irq),
    .legacy_hdr  (legacy_hdr),
    .mask_q      (mask_q),
    .test_mode   (test_mode_o),
    .legacy_mode (legacy_mode_o),
    .status_byte (status_byte),
    .irqreg_byte (irqreg_byte),
    .irq_out     (irq_out)
  );

  always_comb begin
    case (bus_addr)
      PORT_DATA: rd_mux = bank_rd[ptr_chan];
      PORT_PTR:  rd_mux = {{(DW-8){1'b0}}, ptr_readback(ptr_q)};
      PORT_TEST: rd_mux = {{(DW-8){1'b0}}, status_byte};
      default:   rd_mux = {{(DW-8){1'b0}}, irqreg_byte};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_re ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/cfg_ptr_bank_chk.sv
module cfg_ptr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_we,
  input logic        bus_re,
  input logic [15:0] bus_rdata,
  input logic [2:0]  ptr_idx,
  input logic        ptr_step,
  input logic        ptr_wr,
  input logic [1:0]  mask_q,
  input logic [1:0]  irq_out,
  input logic [1:0]  fifo_clr_o,
  input logic [31:0] cmd_base_o,
  input logic [31:0] ctl_base_o
);

  p_mask_gate0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] |-> !irq_out[0]);

  p_mask_gate1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[1] |-> !irq_out[1]);

  p_clr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_clr_o) |-> $past(bus_we && bus_addr == 2'd0));

  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_clr_o));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr_idx >= 3'd6) |=> (ptr_idx == 3'd0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr_idx < 3'd6) |=> (ptr_idx == $past(ptr_idx) + 3'd1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_step && !ptr_wr) |=> $stable(ptr_idx));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == 16'h0));

  p_idx7_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && ptr_idx == 3'd7) |=>
      ($stable(cmd_base_o) && $stable(ctl_base_o)));

endmodule

bind cfg_ptr_bank cfg_ptr_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .ptr_idx    (ptr_idx),
  .ptr_step   (ptr_step),
  .ptr_wr     (ptr_wr),
  .mask_q     (mask_q),
  .irq_out    (irq_out),
  .fifo_clr_o (fifo_clr_o),
  .cmd_base_o (cmd_base_o),
  .ctl_base_o (ctl_base_o)
);

// File: tb/cfg_ptr_bank_test.sv
`timescale 1ns/1ps
module cfg_ptr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [1:0]  drv_irq = 2'b0;
  logic [1:0]  bm_irq = 2'b0;
  logic        legacy_hdr = 1'b0;
  logic [1:0]  irq_out;
  logic [31:0] cmd_base_o, ctl_base_o;
  logic [15:0] gen_cfg_o, dtime_o, ctime_o;
  logic [19:0] ra_count_o;
  logic [1:0]  ra_en_o, mode4_o, fifo_clr_o;
  logic        test_mode_o, legacy_mode_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;

  always #4 clk = ~clk;

  cfg_ptr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .bm_irq(bm_irq), .legacy_hdr(legacy_hdr),
    .irq_out(irq_out), .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o),
    .gen_cfg_o(gen_cfg_o), .ra_count_o(ra_count_o), .ra_en_o(ra_en_o),
    .mode4_o(mode4_o), .dtime_o(dtime_o), .ctime_o(ctime_o),
    .fifo_clr_o(fifo_clr_o), .test_mode_o(test_mode_o),
    .legacy_mode_o(legacy_mode_o)
  );

  // behavioural reference state
  int m_ptr, m_mask, m_test, m_leg, m_rd;
  int m_cmd[2], m_ctl[2], m_gen[2], m_ra[2], m_raen[2], m_m4[2], m_dt[2], m_ct[2], m_clr[2];

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int ch, input int ix);
    if (ix == 0) return m_cmd[ch];
    if (ix == 4) return m_ctl[ch];
    if (ix == 1) return m_gen[ch] & 'hFB;
    if (ix == 5) return m_dt[ch];
    if (ix == 6) return m_ct[ch];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 'h50; m_mask = 0; m_test = 0; m_leg = 0; m_rd = 0;
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = (c == 1) ? 'h170 : 'h1F0;
        m_ctl[c] = (c == 1) ? 'h376 : 'h3F6;
        m_gen[c] = 1; m_ra[c] = 0; m_raen[c] = 0; m_m4[c] = 0;
        m_dt[c] = 'hF5; m_ct[c] = 'hDE; m_clr[c] = 0;
      end
    end else begin
      int ch, ix, v, wd;
      ch = (m_ptr >> 3) & 1;
      ix = m_ptr & 7;
      wd = int'(bus_wdata);
      case (bus_addr)
        2'd0: v = model_read(ch, ix);
        2'd1: v = m_ptr & 'hDF;
        2'd2: v = bm_irq[0] * 2 + drv_irq[0];
        default: v = legacy_hdr * 16 + bm_irq[1] * 8 + drv_irq[1] * 4 + m_mask;
      endcase
      m_rd = bus_re ? v : 0;
      m_clr[0] = 0; m_clr[1] = 0;
      if (bus_we) begin
        case (bus_addr)
          2'd0: begin
            case (ix)
              0: m_cmd[ch] = wd;
              1: m_gen[ch] = wd & 'hFF;
              2: m_ra[ch] = (m_ra[ch] & 'h300) | (wd & 'hFF);
              3: begin
                m_ra[ch] = (m_ra[ch] & 'hFF) | ((wd & 3) << 8);
                m_raen[ch] = (wd >> 7) & 1;
                m_m4[ch] = (wd >> 4) & 1;
                m_clr[ch] = (wd >> 6) & 1;
              end
              4: m_ctl[ch] = wd;
              5: m_dt[ch] = wd & 'hFF;
              6: m_ct[ch] = wd & 'hFF;
              default: ;
            endcase
          end
          2'd1: m_ptr = wd & 'hFF;
          2'd2: begin m_test = wd & 1; m_leg = (wd >> 1) & 1; end
          default: m_mask = wd & 3;
        endcase
      end
      if (bus_addr == 2'd0 && (bus_we || bus_re) && (m_ptr & 'h80) != 0)
        m_ptr = (m_ptr & ~7) | ((ix > 5) ? 0 : ix + 1);
      started = 1;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R12 rdata", bus_rdata, m_rd);
      chk("R9 test_mode", test_mode_o, m_test);
      chk("R9 legacy_mode", legacy_mode_o, m_leg);
      for (int c = 0; c < 2; c++) begin
        int gate;
        gate = ((drv_irq[c] | bm_irq[c]) != 0 && ((m_mask >> c) & 1) == 0) ? 1 : 0;
        chk("R11 irq_out", irq_out[c], gate);
        chk("R4 cmd_base", cmd_base_o[c*16 +: 16], m_cmd[c]);
        chk("R4 ctl_base", ctl_base_o[c*16 +: 16], m_ctl[c]);
        chk("R5 gen_cfg", gen_cfg_o[c*8 +: 8], m_gen[c]);
        chk("R5 dtime", dtime_o[c*8 +: 8], m_dt[c]);
        chk("R5 ctime", ctime_o[c*8 +: 8], m_ct[c]);
        chk("R6 ra_count", ra_count_o[c*10 +: 10], m_ra[c]);
        chk("R6 ra_en", ra_en_o[c], m_raen[c]);
        chk("R6 mode4", mode4_o[c], m_m4[c]);
        chk("R7 fifo_clr", fifo_clr_o[c], m_clr[c]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, 'h50, "R1 pointer reset");
    rd(2'd3, 'h00, "R1 R10 mask reset");
    chk("R1 cmd_base reset", cmd_base_o, 32'h0170_01F0);
    chk("R1 ctl_base reset", ctl_base_o, 32'h0376_03F6);

    // R3 streamed reads through the primary bank with wrap
    wr(2'd1, 16'h0080);
    rd(2'd0, 'h1F0, "R1 R3 idx0");
    rd(2'd0, 'h01,  "R1 R3 idx1");
    rd(2'd0, 'h00,  "R6 idx2 reads zero");
    rd(2'd0, 'h00,  "R6 idx3 reads zero");
    rd(2'd0, 'h3F6, "R1 R3 idx4");
    rd(2'd0, 'hF5,  "R1 R3 idx5");
    rd(2'd0, 'hDE,  "R1 R3 idx6");
    rd(2'd0, 'h1F0, "R3 wrap to idx0");

    // R2 channel select
    wr(2'd1, 16'h0088);
    rd(2'd0, 'h170, "R2 R1 secondary idx0");
    wr(2'd1, 16'h008C);
    rd(2'd0, 'h376, "R2 R1 secondary idx4");

    // R4 write/read without auto-increment
    wr(2'd1, 16'h0008);
    wr(2'd0, 16'h1234);
    rd(2'd0, 'h1234, "R4 R3 hold secondary idx0");
    chk("R4 cmd_base out", cmd_base_o[31:16], 'h1234);

    // R5 general byte, bit 2 write-only
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'hABFF);
    rd(2'd0, 'hFB, "R5 gen readback");
    chk("R5 gen out", gen_cfg_o[7:0], 'hFF);

    // R6 R7 read-ahead and clear pulse
    wr(2'd1, 16'h0082);
    wr(2'd0, 16'h00AB);
    @(posedge clk); #1;
    bus_addr = 2'd0; bus_wdata = 16'h00D3; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    chk("R7 fifo_clr pulse", fifo_clr_o, 2'b01);
    @(posedge clk); #1;
    chk("R7 fifo_clr falls", fifo_clr_o, 2'b00);
    chk("R6 ra_count", ra_count_o[9:0], 'h3AB);
    chk("R6 ra_en/mode4", {ra_en_o[0], mode4_o[0]}, 2'b11);
    rd(2'd0, 'h3F6, "R3 advanced to idx4");

    // R8 index 7
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 'h0, "R8 idx7 reads zero");
    chk("R8 cmd unchanged", cmd_base_o, 32'h1234_01F0);
    rd(2'd1, 'h07, "R2 pointer readback");
    wr(2'd1, 16'h00FF);
    rd(2'd1, 'hDF, "R2 bit5 reads zero");
    rd(2'd0, 'h0, "R3 R8 idx7 read");
    rd(2'd1, 'hD8, "R3 idx7 wraps to 0");

    // R9 test register and channel 0 status
    wr(2'd2, 16'h0083);
    chk("R9 mode bits", {legacy_mode_o, test_mode_o}, 2'b11);
    @(posedge clk); #1;
    drv_irq = 2'b01; bm_irq = 2'b01;
    rd(2'd2, 'h03, "R9 status");

    // R10 R11 mask and channel 1 status
    @(posedge clk); #1;
    drv_irq = 2'b11; bm_irq = 2'b10; legacy_hdr = 1'b1;
    #1 chk("R11 both raised", irq_out, 2'b11);
    rd(2'd3, 'h1C, "R10 status");
    wr(2'd3, 16'h0001);
    chk("R11 ch0 masked", irq_out, 2'b10);
    rd(2'd3, 'h1D, "R10 mask readback");

    // same-cycle: mask write while an input changes
    @(posedge clk); #1;
    bus_addr = 2'd3; bus_wdata = 16'h0002; bus_we = 1'b1;
    drv_irq = 2'b01; bm_irq = 2'b00;
    #1 chk("R11 old mask before edge", irq_out, 2'b00);
    @(posedge clk); #1;
    bus_we = 1'b0;
    chk("R11 new mask after edge", irq_out, 2'b01);

    // R12 idle read data
    repeat (2) @(posedge clk);
    #1 chk("R12 idle rdata", bus_rdata, 0);

    repeat (3) @(posedge clk);
    summary();
  end

endmodule